// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a memory-mapped watchdog for a simple register bus. A down-counter runs while the watchdog is enabled. Software must service it before the count runs out, either by writing a fresh reload value or by clearing the pending interrupt. If the count reaches zero, the block raises an interrupt and starts counting again from the reload value. If the count reaches zero a second time while that interrupt is still pending and the reset path is enabled, the block raises a reset request. The reset request stays high until the block itself is reset.

A guard register protects all writable state. After a write of the 32-bit unlock key 0x1ACCE551, writes are accepted. After a write of any other value, writes to every other register are dropped silently. The bus slave is a plain address, write-data, read-data interface with single-cycle write and read strobes. It decodes a 4 KB window. Read data is combinational by default, and a parameter can select a registered variant instead.

Top module: `wdg_timer`

## Requirements
- R1: After reset, the load register and the current count both read 0xFFFFFFFF. Control reads 0, the lock register reads 0 (unlocked), and raw status, masked status, `wdog_irq` and `wdog_rst` are all 0.
- R2: While control bit 0 (offset 0x008) is 1, the count at offset 0x004 drops by one every clock. While that bit is 0, the count holds.
- R3: When the count is zero at a clock edge and counting is enabled, raw status bit 0 (offset 0x010) is set and the count reloads from the load register. A reload value of L therefore gives an expiry on the (L+1)th clock after enabling.
- R4: Masked status bit 0 (offset 0x014) and `wdog_irq` both equal raw status AND control bit 0. Clearing control bit 0 hides the interrupt but keeps the raw flag.
- R5: Any write to offset 0x00C clears the raw flag and reloads the count from the load register.
- R6: A write to the load register (offset 0x000) stores the value and loads it into the count at once, which services the watchdog.
- R7: Writing 0x1ACCE551 to offset 0xC00 unlocks the block and writing any other value locks it. Reading 0xC00 returns 1 when locked and 0 when unlocked.
- R8: While locked, writes to load, control and interrupt clear have no effect on any register, count or flag.
- R9: When the count expires while the raw flag is already set and control bit 1 is 1, `wdog_rst` goes high and stays high until the block is reset. With control bit 1 at 0, no reset is raised.
- R10: Reads of unmapped offsets and of the write-only clear register return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte offset within the register window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, zero when no read is selected |
| wdog_irq | output | 1 | Timeout interrupt (masked) |
| wdog_rst | output | 1 | Sticky reset request |

## Verification
The hardest condition to reach is the reset request. It needs two expiries in a row with the interrupt left pending in between, and the reset enable set before the first one. The bench sets a small reload value so that each expiry period is only a few clocks long. It enables both control bits in one write and then waits a precise number of cycles. It checks that the reset request is still low one clock before the second expiry and high on the clock of that expiry. It then tries to clear it through the interrupt clear and control registers and checks that the request stays high.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int REG_ADDR_W = 12;
   localparam logic [REG_ADDR_W-1:0] OFS_LOAD  = 12'h000;
   localparam logic [REG_ADDR_W-1:0] OFS_COUNT = 12'h004;
   localparam logic [REG_ADDR_W-1:0] OFS_CTRL  = 12'h008;
   localparam logic [REG_ADDR_W-1:0] OFS_CLR   = 12'h00C;
   localparam logic [REG_ADDR_W-1:0] OFS_RAW   = 12'h010;
   localparam logic [REG_ADDR_W-1:0] OFS_MASK  = 12'h014;
   localparam logic [REG_ADDR_W-1:0] OFS_GUARD = 12'hC00;
   localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

   typedef struct packed {
      logic load;
      logic ctrl;
      logic clr;
      logic guard;
   } wdg_wsel_t;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_LOAD,
      RSEL_COUNT,
      RSEL_CTRL,
      RSEL_RAW,
      RSEL_MASK,
      RSEL_GUARD
   } wdg_rsel_e;
endpackage

// File: rtl/wdg_regbank.sv
module wdg_regbank
   import wdg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter bit RD_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] count,
   input  logic              raw_flag,
   output logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] reload_val,
   output logic              reload,
   output logic              clr_req,
   output logic              ctrl_en,
   output logic              ctrl_rst,
   output logic              locked,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [DATA_W-1:0] LOAD_RST = '1;
   localparam logic [DATA_W-1:0] KEY_W    = DATA_W'(UNLOCK_KEY);

   wdg_wsel_t   wsel;
   wdg_rsel_e   rsel;
   logic        wr_ok;
   logic [DATA_W-1:0] rd_mux;

   function automatic logic hit(input logic [ADDR_W-1:0] a,
                                input logic [REG_ADDR_W-1:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign wr_ok = wr_en && !locked;

   always_comb begin
      wsel.load  = wr_ok && hit(addr, OFS_LOAD);
      wsel.ctrl  = wr_ok && hit(addr, OFS_CTRL);
      wsel.clr   = wr_ok && hit(addr, OFS_CLR);
      wsel.guard = wr_en && hit(addr, OFS_GUARD);
   end

   always_comb begin
      rsel = RSEL_NONE;
      if (hit(addr, OFS_LOAD))       rsel = RSEL_LOAD;
      else if (hit(addr, OFS_COUNT)) rsel = RSEL_COUNT;
      else if (hit(addr, OFS_CTRL))  rsel = RSEL_CTRL;
      else if (hit(addr, OFS_RAW))   rsel = RSEL_RAW;
      else if (hit(addr, OFS_MASK))  rsel = RSEL_MASK;
      else if (hit(addr, OFS_GUARD)) rsel = RSEL_GUARD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_val <= LOAD_RST;
         ctrl_en  <= 1'b0;
         ctrl_rst <= 1'b0;
         locked   <= 1'b0;
      end else begin
         if (wsel.load) load_val <= wdata;
         if (wsel.ctrl) begin
            ctrl_en  <= wdata[0];
            ctrl_rst <= wdata[1];
         end
         if (wsel.guard) locked <= (wdata != KEY_W);
      end
   end

   assign reload     = wsel.load || wsel.clr;
   assign reload_val = wsel.load ? wdata : load_val;
   assign clr_req    = wsel.clr;

   always_comb begin
      rd_mux = '0;
      unique case (rsel)
         RSEL_LOAD:  rd_mux = load_val;
         RSEL_COUNT: rd_mux = count;
         RSEL_CTRL:  rd_mux = DATA_W'({ctrl_rst, ctrl_en});
         RSEL_RAW:   rd_mux = DATA_W'(raw_flag);
         RSEL_MASK:  rd_mux = DATA_W'(raw_flag && ctrl_en);
         RSEL_GUARD: rd_mux = DATA_W'(locked);
         default:    rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata_q <= '0;
            else if (rd_en) rdata_q <= rd_mux;
            else            rdata_q <= '0;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_en ? rd_mux : '0;
      end
   endgenerate
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              reload,
   input  logic [DATA_W-1:0] reload_val,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] count,
   output logic              expire
);
   localparam logic [DATA_W-1:0] CNT_RST = '1;

   logic at_zero;
   assign at_zero = (count == '0);
   assign expire  = en && at_zero && !reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= CNT_RST;
      else if (reload)  count <= reload_val;
      else if (expire)  count <= load_val;
      else if (en)      count <= count - 1'b1;
   end
endmodule

// File: rtl/wdg_alarm.sv
module wdg_alarm (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clr_req,
   input  logic irq_en,
   input  logic rst_en,
   output logic raw_flag,
   output logic irq,
   output logic rst_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_flag <= 1'b0;
         rst_req  <= 1'b0;
      end else begin
         if (clr_req)     raw_flag <= 1'b0;
         else if (expire) raw_flag <= 1'b1;
         if (expire && raw_flag && rst_en) rst_req <= 1'b1;
      end
   end

   assign irq = raw_flag && irq_en;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdog_irq,
   output logic              wdog_rst
);
   generate
      if (DATA_W < 32) begin : g_bad_data_w
         $error("wdg_timer: DATA_W must hold the 32-bit unlock key");
      end
      if (ADDR_W < wdg_pkg::REG_ADDR_W) begin : g_bad_addr_w
         $error("wdg_timer: ADDR_W must cover the 4 KB window");
      end
   endgenerate

   logic [DATA_W-1:0] load_val;
   logic [DATA_W-1:0] reload_val;
   logic [DATA_W-1:0] count;
   logic              reload;
   logic              clr_req;
   logic              ctrl_en;
   logic              ctrl_rst;
   logic              locked;
   logic              expire;
   logic              raw_flag;

   wdg_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_REG(RD_REG)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .wr_en      (bus_wr),
      .rd_en      (bus_rd),
      .count      (count),
      .raw_flag   (raw_flag),
      .load_val   (load_val),
      .reload_val (reload_val),
      .reload     (reload),
      .clr_req    (clr_req),
      .ctrl_en    (ctrl_en),
      .ctrl_rst   (ctrl_rst),
      .locked     (locked),
      .rdata      (bus_rdata)
   );

   wdg_counter #(.DATA_W(DATA_W)) i_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl_en),
      .reload     (reload),
      .reload_val (reload_val),
      .load_val   (load_val),
      .count      (count),
      .expire     (expire)
   );

   wdg_alarm i_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .clr_req  (clr_req),
      .irq_en   (ctrl_en),
      .rst_en   (ctrl_rst),
      .raw_flag (raw_flag),
      .irq      (wdog_irq),
      .rst_req  (wdog_rst)
   );
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              locked,
   input logic              ctrl_en,
   input logic              ctrl_rst,
   input logic              raw_flag,
   input logic [DATA_W-1:0] count,
   input logic [DATA_W-1:0] load_val,
   input logic              wdog_irq,
   input logic              wdog_rst
);
   // R9: once raised, the reset request never drops before system reset
   assert_rst_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |=> wdog_rst);

   // R9: a new reset request needs a pending flag and the reset enable
   assert_rst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_rst) |-> ($past(raw_flag) && $past(ctrl_rst)));

   // R3: the raw flag only rises after an enabled count at zero
   assert_raw_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_flag) |-> ($past(count) == '0 && $past(ctrl_en)));

   // R3: expiry with no bus write reloads the count from the load register
   assert_reload_after_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && count == '0 && !bus_wr) |=> (count == $past(load_val)));

   // R2: a disabled counter with no bus write holds its value
   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !bus_wr) |=> $stable(count));

   // R8: the load register cannot change while locked
   assert_locked_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(load_val));

   // R4: the interrupt never shows without a pending raw flag
   assert_irq_needs_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_irq |-> raw_flag);
endmodule

bind wdg_timer wdg_timer_chk #(.DATA_W(DATA_W)) i_wdg_timer_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .locked   (locked),
   .ctrl_en  (ctrl_en),
   .ctrl_rst (ctrl_rst),
   .raw_flag (raw_flag),
   .count    (count),
   .load_val (load_val),
   .wdog_irq (wdog_irq),
   .wdog_rst (wdog_rst)
);

// File: tb/test_wdg_timer.sv
`timescale 1ns/1ps
module test_wdg_timer;
   localparam int DW = 32;
   localparam int AW = 12;
   localparam logic [31:0] KEY = 32'h1ACC_E551;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic          wdog_irq;
   logic          wdog_rst;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wdg_timer #(.DATA_W(DW), .ADDR_W(AW)) i_wdg_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .wdog_irq(wdog_irq), .wdog_rst(wdog_rst));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      do_reset();
      rd(12'h000, v); check("R1", "load after reset", v, 32'hFFFF_FFFF);
      rd(12'h004, v); check("R1", "count after reset", v, 32'hFFFF_FFFF);
      rd(12'h008, v); check("R1", "ctrl after reset", v, 0);
      rd(12'hC00, v); check("R1", "lock after reset", v, 0);
      rd(12'h010, v); check("R1", "raw after reset", v, 0);
      check("R1", "irq after reset", 32'(wdog_irq), 0);
      check("R1", "rst after reset", 32'(wdog_rst), 0);
   endtask

   task automatic t_count_expire();
      logic [31:0] v;
      do_reset();
      wr(12'h000, 5);
      wait_clk(3);
      rd(12'h004, v); check("R2", "count holds while disabled", v, 5);
      wr(12'h008, 1);
      rd(12'h004, v); check("R2", "count right after enable", v, 5);
      wait_clk(1);
      rd(12'h004, v); check("R2", "count one clock later", v, 4);
      wait_clk(4);
      rd(12'h004, v); check("R2", "count reaches zero", v, 0);
      rd(12'h010, v); check("R3", "raw not yet set", v, 0);
      wait_clk(1);
      rd(12'h010, v); check("R3", "raw set at expiry", v, 1);
      rd(12'h004, v); check("R3", "count reloaded", v, 5);
      rd(12'h014, v); check("R4", "masked while enabled", v, 1);
      check("R4", "irq while enabled", 32'(wdog_irq), 1);
      wr(12'h008, 0);
      rd(12'h010, v); check("R4", "raw kept when disabled", v, 1);
      rd(12'h014, v); check("R4", "masked hidden when disabled", v, 0);
      check("R4", "irq hidden when disabled", 32'(wdog_irq), 0);
   endtask

   task automatic t_kick_clear();
      logic [31:0] v;
      do_reset();
      wr(12'h000, 5);
      wr(12'h008, 1);
      wait_clk(4);
      wr(12'h000, 5);
      rd(12'h004, v); check("R6", "load write reloads count", v, 5);
      wait_clk(5);
      rd(12'h010, v); check("R6", "kick postpones expiry", v, 0);
      wait_clk(1);
      rd(12'h010, v); check("R6", "expiry after kicked period", v, 1);
      wait_clk(2);
      wr(12'h00C, 32'h0);
      rd(12'h010, v); check("R5", "clear drops raw", v, 0);
      rd(12'h004, v); check("R5", "clear reloads count", v, 5);
      check("R5", "irq after clear", 32'(wdog_irq), 0);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      do_reset();
      wr(12'hC00, 32'h0000_0001);
      rd(12'hC00, v); check("R7", "lock reads 1", v, 1);
      wr(12'h000, 7);
      rd(12'h000, v); check("R8", "locked load write ignored", v, 32'hFFFF_FFFF);
      rd(12'h004, v); check("R8", "locked load write no reload", v, 32'hFFFF_FFFF);
      wr(12'h008, 3);
      rd(12'h008, v); check("R8", "locked ctrl write ignored", v, 0);
      wr(12'hC00, KEY);
      rd(12'hC00, v); check("R7", "key unlocks", v, 0);
      wr(12'h000, 2);
      rd(12'h000, v); check("R7", "unlocked load write", v, 2);
      wr(12'h008, 1);
      wait_clk(3);
      rd(12'h010, v); check("R3", "raw set with load 2", v, 1);
      wr(12'h008, 0);
      wr(12'hC00, 32'h0000_DEAD);
      rd(12'hC00, v); check("R7", "other value locks", v, 1);
      wr(12'h00C, 32'hFFFF_FFFF);
      rd(12'h010, v); check("R8", "locked clear ignored", v, 1);
   endtask

   task automatic t_reset_request();
      logic [31:0] v;
      do_reset();
      wr(12'h000, 5);
      wr(12'h008, 1);
      wait_clk(12);
      rd(12'h010, v); check("R9", "raw pending, reset disabled", v, 1);
      check("R9", "no reset without enable", 32'(wdog_rst), 0);
      do_reset();
      wr(12'h000, 5);
      wr(12'h008, 3);
      wait_clk(6);
      check("R9", "first expiry raises irq", 32'(wdog_irq), 1);
      check("R9", "first expiry no reset", 32'(wdog_rst), 0);
      wait_clk(5);
      check("R9", "reset low before second expiry", 32'(wdog_rst), 0);
      wait_clk(1);
      check("R9", "reset at second expiry", 32'(wdog_rst), 1);
      wr(12'h00C, 1);
      wr(12'h008, 0);
      wait_clk(3);
      check("R9", "reset stays high", 32'(wdog_rst), 1);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      do_reset();
      wr(12'h000, 9);
      wr(12'h018, 32'hFFFF_FFFF);
      wr(12'hFFC, 32'hFFFF_FFFF);
      rd(12'h018, v); check("R10", "unmapped read 0x018", v, 0);
      rd(12'hFFC, v); check("R10", "unmapped read 0xFFC", v, 0);
      rd(12'h00C, v); check("R10", "clear register reads 0", v, 0);
      rd(12'h000, v); check("R10", "load untouched", v, 9);
      rd(12'h008, v); check("R10", "ctrl untouched", v, 0);
      rd(12'h004, v); check("R10", "count untouched", v, 9);
   endtask

   initial begin
      t_reset_state();
      t_count_expire();
      t_kick_clear();
      t_lock();
      t_reset_request();
      t_unmapped();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule